// File: doc/BRIEF.md
# Interrupt Request Acceptance Unit

This unit decides whether a pending hardware interrupt is taken at an instruction boundary. Five request lines are sampled into a register. The highest-numbered active line gives the request level. That level is then compared against the processor's current interrupt level and against three status flags that block acceptance: interrupt disable, exception pending and fatal pending. When the unit accepts an interrupt, it raises a one-cycle strobe together with a 16-bit cause code. The cause code is a fixed base value with the level packed into a small field.

The surrounding core asserts `fetch_start` in the cycle in which a fetch begins, after the program counter has been loaded. It holds `cpu_halted` high while it sits in the halt state. In halt, the check runs on every cycle. An accepted interrupt during halt also raises `halt_wake`, so the core can leave the halt state. Vectoring, saving state and updating the status word belong to the exception entry logic, which consumes the strobe and the cause.

Top module: `irq_accept_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_take`, `halt_wake` and `irq_cause` are all zero after that edge.
- R2: The request level is the index (0 to 4) of the highest set bit of the sampled request lines. An accepted interrupt outputs `irq_cause` = 0xFE00 with that level in bits 6:4, which is 0xFE00 | (level << 4).
- R3: No interrupt is accepted in a check cycle in which any of `psw_id`, `psw_ep` or `psw_np` is high.
- R4: A nonempty request is accepted only when its level, read as an unsigned number, is greater than or equal to the 4-bit `psw_ilvl`.
- R5: When all sampled request lines are zero, no interrupt is accepted, whatever `psw_ilvl` holds.
- R6: A check happens only in a cycle with `fetch_start` or `cpu_halted` high. In any other cycle, no interrupt is accepted.
- R7: The request lines reach the decision one cycle after they are presented, through a register. The status flags, `fetch_start` and `cpu_halted` act in the check cycle itself. `irq_take` appears in the cycle after the check.
- R8: `irq_take` is never high on two consecutive cycles. The cycle that follows an accept performs no check.
- R9: `halt_wake` is high exactly when `irq_take` is high and `cpu_halted` was high in the check cycle. `irq_cause` is zero whenever `irq_take` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 5 | Interrupt request lines, bit index is the level |
| psw_id | input | 1 | Interrupt disable flag |
| psw_ep | input | 1 | Exception pending flag |
| psw_np | input | 1 | Fatal pending flag |
| psw_ilvl | input | 4 | Current interrupt level; a request must be at or above it |
| fetch_start | input | 1 | A fetch begins in this cycle |
| cpu_halted | input | 1 | The core is in the halt state |
| irq_take | output | 1 | One-cycle interrupt accept strobe |
| irq_cause | output | 16 | Cause code, valid with `irq_take` |
| halt_wake | output | 1 | The accepted interrupt ends the halt state |

## Verification
The hardest situation to reach is a halted core that waits through several blocked cycles and then accepts. This needs a level below the threshold first, a raised request after that, and the one-cycle lag of the request register. The stimulus holds `cpu_halted` high, presents a low request under a high `psw_ilvl`, and then lifts the request to the top line. It keeps halt asserted past the accept, which shows both the wake pulse and the gap cycle that follows each strobe. A full sweep of all 32 request masks against several threshold values and all eight flag combinations covers the level comparison and the blocking flags. Each case loads the mask one cycle before the fetch strobe.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int unsigned IRQ_LINES_DEF = 5;
  localparam int unsigned ILVL_W_DEF    = 4;
  localparam int unsigned CAUSE_W_DEF   = 16;
  localparam logic [15:0] IRQ_CAUSE_BASE = 16'hFE00;
  localparam int unsigned IRQ_LVL_LSB   = 4;

  typedef struct packed {
    logic id;
    logic ep;
    logic np;
  } psw_block_t;

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 5,
  parameter int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [LW-1:0] level
);

  // above[i] is set when some line with a higher index is active
  logic [N-1:0] above;
  logic [N-1:0] winner;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chain
      if (i == N - 1) begin : g_top
        assign above[i] = 1'b0;
      end else begin : g_mid
        assign above[i] = above[i+1] | req[i+1];
      end
      assign winner[i] = req[i] & ~above[i];
    end
  endgenerate

  always_comb begin
    level = '0;
    for (int i = 0; i < N; i++) begin
      if (winner[i]) level = level | LW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_accept_pkg::*;
#(
  parameter int unsigned LW        = 3,
  parameter int unsigned ILVL_W    = 4,
  parameter int unsigned CAUSE_W   = 16,
  parameter logic [15:0] BASE      = IRQ_CAUSE_BASE,
  parameter int unsigned LVL_LSB   = IRQ_LVL_LSB
) (
  input  logic               check_en,
  input  logic               req_any,
  input  logic [LW-1:0]      req_level,
  input  psw_block_t         blk,
  input  logic [ILVL_W-1:0]  ilvl,
  output logic               take,
  output logic [CAUSE_W-1:0] cause
);

  localparam int unsigned CMP_W = (LW > ILVL_W) ? LW : ILVL_W;

  logic [CMP_W-1:0] lvl_ext;
  logic [CMP_W-1:0] thr_ext;
  logic             blocked;
  logic             level_ok;

  assign lvl_ext  = CMP_W'(req_level);
  assign thr_ext  = CMP_W'(ilvl);
  assign blocked  = blk.id | blk.ep | blk.np;
  assign level_ok = (lvl_ext >= thr_ext);

  always_comb begin
    take  = check_en & req_any & ~blocked & level_ok;
    cause = '0;
    if (take) begin
      cause = CAUSE_W'(BASE) | (CAUSE_W'(req_level) << LVL_LSB);
    end
  end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int unsigned NUM_LINES = IRQ_LINES_DEF,
  parameter int unsigned ILVL_W    = ILVL_W_DEF,
  parameter int unsigned CAUSE_W   = CAUSE_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 psw_id,
  input  logic                 psw_ep,
  input  logic                 psw_np,
  input  logic [ILVL_W-1:0]    psw_ilvl,
  input  logic                 fetch_start,
  input  logic                 cpu_halted,
  output logic                 irq_take,
  output logic [CAUSE_W-1:0]   irq_cause,
  output logic                 halt_wake
);

  localparam int unsigned LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] req_q;
  logic                 req_any;
  logic [LW-1:0]        req_level;
  logic                 check_en;
  logic                 take_d;
  logic [CAUSE_W-1:0]   cause_d;
  psw_block_t           blk;

  irq_req_sync #(.N(NUM_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_req),
    .q   (req_q)
  );

  irq_prio_enc #(.N(NUM_LINES), .LW(LW)) u_enc (
    .req   (req_q),
    .any   (req_any),
    .level (req_level)
  );

  assign blk.id = psw_id;
  assign blk.ep = psw_ep;
  assign blk.np = psw_np;

  // the cycle after an accept belongs to exception entry: no new check
  assign check_en = (fetch_start | cpu_halted) & ~irq_take;

  irq_accept_gate #(
    .LW      (LW),
    .ILVL_W  (ILVL_W),
    .CAUSE_W (CAUSE_W)
  ) u_gate (
    .check_en  (check_en),
    .req_any   (req_any),
    .req_level (req_level),
    .blk       (blk),
    .ilvl      (psw_ilvl),
    .take      (take_d),
    .cause     (cause_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_take  <= 1'b0;
      irq_cause <= '0;
      halt_wake <= 1'b0;
    end else begin
      irq_take  <= take_d;
      irq_cause <= cause_d;
      halt_wake <= take_d & cpu_halted;
    end
  end

endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk #(
  parameter int unsigned NUM_LINES = 5,
  parameter int unsigned ILVL_W    = 4,
  parameter int unsigned CAUSE_W   = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] irq_req,
  input logic                 psw_id,
  input logic                 psw_ep,
  input logic                 psw_np,
  input logic [ILVL_W-1:0]    psw_ilvl,
  input logic                 fetch_start,
  input logic                 cpu_halted,
  input logic                 irq_take,
  input logic [CAUSE_W-1:0]   irq_cause,
  input logic                 halt_wake
);

  localparam logic [CAUSE_W-1:0] FIELD = CAUSE_W'(16'h0070);
  localparam logic [CAUSE_W-1:0] BASE  = CAUSE_W'(16'hFE00);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_take && !halt_wake && irq_cause == '0));

  a_r2_cause_form: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> ((irq_cause & ~FIELD) == BASE
                  && ((irq_cause & FIELD) >> 4) < CAUSE_W'(NUM_LINES)));

  a_r3_flags_block: assert property (@(posedge clk) disable iff (rst)
    (psw_id || psw_ep || psw_np) |=> !irq_take);

  a_r6_no_check_idle: assert property (@(posedge clk) disable iff (rst)
    (!fetch_start && !cpu_halted) |=> !irq_take);

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take);

  a_r9_wake_with_take: assert property (@(posedge clk) disable iff (rst)
    halt_wake |-> irq_take);

  a_r9_cause_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_take |-> irq_cause == '0);

endmodule

bind irq_accept_unit irq_accept_unit_chk #(
  .NUM_LINES (NUM_LINES),
  .ILVL_W    (ILVL_W),
  .CAUSE_W   (CAUSE_W)
) u_chk (.*);

// File: tb/irq_accept_unit_test.sv
module irq_accept_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  irq_req = '0;
  logic        psw_id = 1'b0, psw_ep = 1'b0, psw_np = 1'b0;
  logic [3:0]  psw_ilvl = '0;
  logic        fetch_start = 1'b0, cpu_halted = 1'b0;
  logic        irq_take;
  logic [15:0] irq_cause;
  logic        halt_wake;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // reference state
  logic [4:0] m_req_q = '0;
  logic       m_take  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_unit uut (
    .clk(clk), .rst(rst), .irq_req(irq_req),
    .psw_id(psw_id), .psw_ep(psw_ep), .psw_np(psw_np),
    .psw_ilvl(psw_ilvl), .fetch_start(fetch_start), .cpu_halted(cpu_halted),
    .irq_take(irq_take), .irq_cause(irq_cause), .halt_wake(halt_wake)
  );

  function automatic int top_level(input logic [4:0] m);
    int lv = -1;
    for (int i = 0; i < 5; i++) if (m[i]) lv = i;
    return lv;
  endfunction

  task automatic step(input logic [4:0] rq, input logic [2:0] flg,
                      input logic [3:0] il, input logic fs, input logic hl,
                      input logic rs);
    logic        e_take, e_wake;
    logic [15:0] e_cause;
    int          lv;
    rst = rs; irq_req = rq; {psw_id, psw_ep, psw_np} = flg;
    psw_ilvl = il; fetch_start = fs; cpu_halted = hl;
    if (rs) begin
      e_take = 0; e_wake = 0; e_cause = 0; m_req_q = '0;
    end else begin
      lv = top_level(m_req_q);
      e_take = (lv >= 0) && (flg == 3'b000) && (lv >= int'(il))
               && (fs || hl) && !m_take;
      e_cause = e_take ? (16'hFE00 | 16'(lv << 4)) : 16'h0000;
      e_wake = e_take && hl;
      m_req_q = rq;
    end
    m_take = e_take;
    @(negedge clk);
    checks++;
    if (irq_take !== e_take || irq_cause !== e_cause || halt_wake !== e_wake) begin
      fails++;
      $display("FAIL %s: take/cause/wake = %b/%h/%b expected %b/%h/%b",
               cur_req, irq_take, irq_cause, halt_wake, e_take, e_cause, e_wake);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ivals[7] = '{0, 1, 2, 3, 4, 5, 15};
    // R1: reset with busy inputs
    cur_req = "R1";
    repeat (3) step(5'b11111, 3'b000, 4'd0, 1'b1, 1'b1, 1'b1);
    step(5'b00000, 3'b000, 4'd0, 1'b0, 1'b0, 1'b0);

    // Full sweep: mask x threshold x flags
    for (int m = 0; m < 32; m++) begin
      for (int k = 0; k < 7; k++) begin
        for (int f = 0; f < 8; f++) begin
          if (f != 0)                          cur_req = "R3";
          else if (m == 0)                     cur_req = "R5";
          else if (top_level(5'(m)) >= ivals[k]) cur_req = "R2";
          else                                 cur_req = "R4";
          step(5'(m), 3'(f), 4'(ivals[k]), 1'b0, 1'b0, 1'b0);
          step(5'(m), 3'(f), 4'(ivals[k]), 1'b1, 1'b0, 1'b0);
          step(5'b0, 3'b000, 4'd0, 1'b0, 1'b0, 1'b0);
        end
      end
    end

    // R6: request held, no fetch and no halt
    cur_req = "R6";
    repeat (4) step(5'b10000, 3'b000, 4'd0, 1'b0, 1'b0, 1'b0);

    // R7: request and fetch arrive together from an empty register
    cur_req = "R7";
    step(5'b00000, 3'b000, 4'd0, 1'b0, 1'b0, 1'b0);
    step(5'b01000, 3'b000, 4'd0, 1'b1, 1'b0, 1'b0);
    step(5'b01000, 3'b000, 4'd0, 1'b0, 1'b0, 1'b0);
    step(5'b00000, 3'b000, 4'd0, 1'b0, 1'b0, 1'b0);

    // R8: fetch strobe held with request held
    cur_req = "R8";
    repeat (5) step(5'b00100, 3'b000, 4'd1, 1'b1, 1'b0, 1'b0);
    step(5'b00000, 3'b000, 4'd0, 1'b0, 1'b0, 1'b0);

    // R9: halted, low request blocked by threshold, then top line raised
    cur_req = "R9";
    repeat (4) step(5'b00001, 3'b000, 4'd4, 1'b0, 1'b1, 1'b0);
    repeat (5) step(5'b10001, 3'b000, 4'd4, 1'b0, 1'b1, 1'b0);
    step(5'b00000, 3'b000, 4'd4, 1'b0, 1'b0, 1'b0);
    // halted with exception pending: no wake
    repeat (3) step(5'b10000, 3'b010, 4'd0, 1'b0, 1'b1, 1'b0);
    step(5'b00000, 3'b000, 4'd0, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule